// File: doc/BRIEF.md
# Paged Alias Access Guard

This block sits between a system bus and one on-chip memory. The memory can be reached through two address windows of the same size: a secure window and a non-secure window. Both windows lead to the same physical bytes. The memory is divided into pages of equal size. A small register file holds one bit per page that marks the page as secure or non-secure. For each bus request the guard works out which window was used and which page is targeted. It then compares the window, the page bit and the security state of the requester, and either passes the request to the memory or blocks it.

A request that passes reaches the memory port in the same cycle. Its address is the request address minus the base of the window it used, which is the physical byte offset. A blocked request never reaches the memory. It still gets a response one cycle later, with the error flag set and zero read data. A blocked request also sets a sticky violation interrupt that stays high until it is cleared. Only secure configuration writes can change the page bits, and at reset every page is secure.

With the default parameters the memory is 64 KB in 4 KB pages. The secure window starts at 0x1000_0000 and the non-secure window starts at 0x2000_0000. So physical byte 0x0000 appears at 0x1000_0000 on the secure window and at 0x2000_0000 on the non-secure window.

Top module: `alias_page_guard`

## Requirements
- R1: A request on the secure window (default base 0x1000_0000) from a secure requester (`req_nonsec`=0) to a page whose bit is 0 is forwarded in the same cycle: `mem_valid`=1 and `mem_addr` = request address minus the secure base.
- R2: A request on the non-secure window (default base 0x2000_0000) from a non-secure requester (`req_nonsec`=1) to a page whose bit is 1 is forwarded in the same cycle, with `mem_addr` = request address minus the non-secure base.
- R3: A non-secure requester using the secure window is always blocked, whatever the page bit.
- R4: A request whose window does not match the target page's bit is blocked. This means secure window to a page with bit 1, or non-secure window to a page with bit 0.
- R5: A secure requester using the non-secure window is blocked, even when the page bit is 1.
- R6: A request whose address falls in neither window is blocked.
- R7: Every request gets a response one cycle later (`rsp_valid`=1). For a blocked request `rsp_err`=1, `rsp_rdata`=0 and nothing reaches the memory port, so writes are dropped. For a forwarded read `rsp_err`=0 and `rsp_rdata` equals `mem_rdata` in that cycle.
- R8: `viol_irq` rises in the cycle after a blocked request and stays high until `viol_clr` is pulsed. If a new block and a clear happen in the same cycle, the interrupt stays set.
- R9: A configuration write (`cfg_wr`=1) sets the bit of page `cfg_page` to `cfg_value` (1 = non-secure, 0 = secure). The new value takes effect on the next cycle, and only if `cfg_nonsec`=0. Writes with `cfg_nonsec`=1 are ignored.
- R10: After reset every page bit is 0 (secure), `rsp_valid`=0 and `viol_irq`=0.
- R11: The page index is the physical offset bits just above the page offset, which is bits [15:12] by default. The last byte of a page uses that page's bit, and the first byte of the next page uses the next page's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_addr | input | ADDR_W | Request byte address (alias address) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_nonsec | input | 1 | Requester security state, 1 = non-secure |
| mem_valid | output | 1 | Forwarded request to memory |
| mem_addr | output | ADDR_W | Physical byte address (alias base removed) |
| mem_write | output | 1 | Forwarded write enable |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Response carries an access error |
| rsp_rdata | output | DATA_W | Read data, zero on error |
| cfg_wr | input | 1 | Page bit write strobe |
| cfg_nonsec | input | 1 | Security state of the configuration writer, 1 = non-secure |
| cfg_page | input | IDX_W | Page index to write |
| cfg_value | input | 1 | New page bit, 1 = non-secure |
| viol_irq | output | 1 | Sticky violation interrupt |
| viol_clr | input | 1 | Clears the violation interrupt |

## Verification
The bench probes the three-way match between window, page bit and requester state. Each mismatch is tried separately:
- A guard that only compares the window with the page bit would pass a secure requester through the non-secure window.
- A guard that ignores the requester would let non-secure code read secure pages through the secure window.

Page edges are tested on both sides of a boundary, because an index taken from the wrong bits would apply the neighbouring page's bit. Two more cases are tested:
- A non-secure configuration write, which a guard with a missing privilege check would accept.
- A block that arrives together with an interrupt clear, which a guard with the wrong priority would lose.

// File: rtl/apg_pkg.sv
package apg_pkg;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_SEC  = 2'd1,
      WIN_NS   = 2'd2
   } win_e;

   function automatic int unsigned idx_bits(input int unsigned pages);
      return (pages > 1) ? $clog2(pages) : 1;
   endfunction

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/apg_alias_decode.sv
module apg_alias_decode
   import apg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned MEM_BYTES  = 65536,
   parameter int unsigned PAGE_BYTES = 4096,
   parameter logic [ADDR_W-1:0] SEC_BASE = 32'h1000_0000,
   parameter logic [ADDR_W-1:0] NS_BASE  = 32'h2000_0000,
   localparam int unsigned NUM_PAGES = MEM_BYTES / PAGE_BYTES,
   localparam int unsigned IDX_W     = idx_bits(NUM_PAGES)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output win_e              win_o,
   output logic [ADDR_W-1:0] phys_o,
   output logic [IDX_W-1:0]  page_o
);
   localparam int unsigned PG_W = $clog2(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] SIZE = ADDR_W'(MEM_BYTES);

   logic              hit_sec, hit_ns;
   logic [ADDR_W-1:0] off_sec, off_ns;

   assign off_sec = addr_i - SEC_BASE;
   assign off_ns  = addr_i - NS_BASE;

   generate
      if (is_pow2(MEM_BYTES)) begin : g_tag_cmp
         localparam int unsigned OFF_W = $clog2(MEM_BYTES);
         assign hit_sec = (addr_i[ADDR_W-1:OFF_W] == SEC_BASE[ADDR_W-1:OFF_W]);
         assign hit_ns  = (addr_i[ADDR_W-1:OFF_W] == NS_BASE[ADDR_W-1:OFF_W]);
      end else begin : g_range_cmp
         assign hit_sec = (addr_i >= SEC_BASE) && (off_sec < SIZE);
         assign hit_ns  = (addr_i >= NS_BASE)  && (off_ns  < SIZE);
      end
   endgenerate

   always_comb begin
      if (hit_sec) begin
         win_o  = WIN_SEC;
         phys_o = off_sec;
      end else if (hit_ns) begin
         win_o  = WIN_NS;
         phys_o = off_ns;
      end else begin
         win_o  = WIN_NONE;
         phys_o = '0;
      end
   end

   assign page_o = phys_o[PG_W +: IDX_W];

endmodule

// File: rtl/apg_page_table.sv
module apg_page_table
   import apg_pkg::*;
#(
   parameter int unsigned NUM_PAGES = 16,
   localparam int unsigned IDX_W    = idx_bits(NUM_PAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [IDX_W-1:0]     wr_idx_i,
   input  logic                 wr_val_i,
   input  logic [IDX_W-1:0]     rd_idx_i,
   output logic                 rd_ns_o,
   output logic [NUM_PAGES-1:0] ns_vec_o
);
   logic [NUM_PAGES-1:0] ns_q;

   generate
      for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ns_q[g] <= 1'b0;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
               ns_q[g] <= wr_val_i;
         end
      end
   endgenerate

   always_comb begin
      rd_ns_o = 1'b0;
      for (int i = 0; i < NUM_PAGES; i++)
         if (rd_idx_i == IDX_W'(i)) rd_ns_o = ns_q[i];
   end

   assign ns_vec_o = ns_q;

endmodule

// File: rtl/apg_access_judge.sv
module apg_access_judge
   import apg_pkg::*;
(
   input  logic valid_i,
   input  win_e win_i,
   input  logic page_ns_i,
   input  logic req_ns_i,
   output logic grant_o,
   output logic deny_o
);
   logic via_ns, ok;

   assign via_ns  = (win_i == WIN_NS);
   assign ok      = (win_i != WIN_NONE) && (via_ns == page_ns_i) && (via_ns == req_ns_i);
   assign grant_o = valid_i && ok;
   assign deny_o  = valid_i && !ok;

endmodule

// File: rtl/apg_resp_stage.sv
module apg_resp_stage #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_i,
   input  logic              deny_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_err_o,
   output logic [DATA_W-1:0] rsp_rdata_o,
   output logic              irq_o
);
   logic vld_q, err_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         err_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         vld_q <= grant_i | deny_i;
         err_q <= deny_i;
         if (deny_i)
            irq_q <= 1'b1;
         else if (clr_i)
            irq_q <= 1'b0;
      end
   end

   assign rsp_valid_o = vld_q;
   assign rsp_err_o   = err_q;
   assign rsp_rdata_o = (vld_q && !err_q) ? mem_rdata_i : '0;
   assign irq_o       = irq_q;

endmodule

// File: rtl/alias_page_guard.sv
module alias_page_guard
   import apg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MEM_BYTES  = 65536,
   parameter int unsigned PAGE_BYTES = 4096,
   parameter logic [ADDR_W-1:0] SEC_BASE = 32'h1000_0000,
   parameter logic [ADDR_W-1:0] NS_BASE  = 32'h2000_0000,
   localparam int unsigned NUM_PAGES = MEM_BYTES / PAGE_BYTES,
   localparam int unsigned IDX_W     = idx_bits(NUM_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_nonsec,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_write,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              cfg_wr,
   input  logic              cfg_nonsec,
   input  logic [IDX_W-1:0]  cfg_page,
   input  logic              cfg_value,
   output logic              viol_irq,
   input  logic              viol_clr
);
   generate
      if (!is_pow2(PAGE_BYTES)) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if ((MEM_BYTES % PAGE_BYTES) != 0 || NUM_PAGES < 2) begin : g_bad_mem
         $error("MEM_BYTES must hold at least two whole pages");
      end
      if ((SEC_BASE % PAGE_BYTES) != 0 || (NS_BASE % PAGE_BYTES) != 0) begin : g_bad_align
         $error("window bases must be page aligned");
      end
      if (is_pow2(MEM_BYTES) && (((SEC_BASE % MEM_BYTES) != 0) || ((NS_BASE % MEM_BYTES) != 0))) begin : g_bad_tag
         $error("power-of-two memory needs size-aligned window bases");
      end
      if ((SEC_BASE < NS_BASE) ? (NS_BASE - SEC_BASE < MEM_BYTES)
                               : (SEC_BASE - NS_BASE < MEM_BYTES)) begin : g_overlap
         $error("secure and non-secure windows overlap");
      end
   endgenerate

   win_e                 win;
   logic [ADDR_W-1:0]    phys;
   logic [IDX_W-1:0]     page_idx;
   logic                 page_ns;
   logic                 grant, deny;
   logic [NUM_PAGES-1:0] page_ns_vec;

   apg_alias_decode #(
      .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
      .SEC_BASE(SEC_BASE), .NS_BASE(NS_BASE)
   ) u_decode (
      .addr_i (req_addr),
      .win_o  (win),
      .phys_o (phys),
      .page_o (page_idx)
   );

   apg_page_table #(.NUM_PAGES(NUM_PAGES)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (cfg_wr && !cfg_nonsec),
      .wr_idx_i (cfg_page),
      .wr_val_i (cfg_value),
      .rd_idx_i (page_idx),
      .rd_ns_o  (page_ns),
      .ns_vec_o (page_ns_vec)
   );

   apg_access_judge u_judge (
      .valid_i   (req_valid),
      .win_i     (win),
      .page_ns_i (page_ns),
      .req_ns_i  (req_nonsec),
      .grant_o   (grant),
      .deny_o    (deny)
   );

   apg_resp_stage #(.DATA_W(DATA_W)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .grant_i     (grant),
      .deny_i      (deny),
      .clr_i       (viol_clr),
      .mem_rdata_i (mem_rdata),
      .rsp_valid_o (rsp_valid),
      .rsp_err_o   (rsp_err),
      .rsp_rdata_o (rsp_rdata),
      .irq_o       (viol_irq)
   );

   assign mem_valid = grant;
   assign mem_addr  = phys;
   assign mem_write = req_write;
   assign mem_wdata = req_wdata;

endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MEM_BYTES  = 65536,
   parameter int unsigned NUM_PAGES  = 16,
   parameter logic [ADDR_W-1:0] SEC_BASE = 32'h1000_0000,
   parameter logic [ADDR_W-1:0] NS_BASE  = 32'h2000_0000
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 req_write,
   input logic                 req_nonsec,
   input logic                 mem_valid,
   input logic [ADDR_W-1:0]    mem_addr,
   input logic                 mem_write,
   input logic                 rsp_valid,
   input logic                 rsp_err,
   input logic [DATA_W-1:0]    rsp_rdata,
   input logic                 cfg_wr,
   input logic                 cfg_nonsec,
   input logic                 viol_irq,
   input logic                 viol_clr,
   input logic [NUM_PAGES-1:0] page_vec
);
   localparam logic [ADDR_W-1:0] SIZE = ADDR_W'(MEM_BYTES);

   logic in_sec, in_ns;
   assign in_sec = (req_addr >= SEC_BASE) && ((req_addr - SEC_BASE) < SIZE);
   assign in_ns  = (req_addr >= NS_BASE)  && ((req_addr - NS_BASE)  < SIZE);

   AST_NS_ON_SEC_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_nonsec && in_sec |-> !mem_valid); // R3

   AST_SEC_ON_NS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_nonsec && in_ns |-> !mem_valid); // R5

   AST_OUTSIDE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !in_sec && !in_ns |-> !mem_valid); // R6

   AST_ADDR_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr == req_addr - SEC_BASE) || (mem_addr == req_addr - NS_BASE)); // R1

   AST_FWD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_write == req_write); // R2

   AST_BLOCK_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !mem_valid |=> rsp_valid && rsp_err); // R7

   AST_GRANT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |=> rsp_valid && !rsp_err); // R7

   AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_rdata == '0); // R7

   AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> viol_irq); // R8

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_irq && !viol_clr |=> viol_irq); // R8

   AST_NS_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && cfg_nonsec |=> $stable(page_vec)); // R9

endmodule

bind alias_page_guard apg_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES),
   .NUM_PAGES(NUM_PAGES), .SEC_BASE(SEC_BASE), .NS_BASE(NS_BASE)
) u_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .req_write(req_write), .req_nonsec(req_nonsec), .mem_valid(mem_valid),
   .mem_addr(mem_addr), .mem_write(mem_write), .rsp_valid(rsp_valid),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_wr(cfg_wr),
   .cfg_nonsec(cfg_nonsec), .viol_irq(viol_irq), .viol_clr(viol_clr),
   .page_vec(page_ns_vec)
);

// File: tb/alias_page_guard_tb.sv
`timescale 1ns/1ps
module alias_page_guard_tb;
   localparam logic [31:0] SEC = 32'h1000_0000;
   localparam logic [31:0] NSB = 32'h2000_0000;
   localparam logic [31:0] PAT = 32'h5A5A_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_nonsec = 0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        mem_valid, mem_write;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        cfg_wr = 0, cfg_nonsec = 0, cfg_value = 0;
   logic [3:0]  cfg_page = '0;
   logic        viol_irq;
   logic        viol_clr = 0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   always @(posedge clk)
      if (mem_valid && !mem_write) mem_rdata <= mem_addr ^ PAT;

   alias_page_guard u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata), .req_nonsec(req_nonsec),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_wr(cfg_wr),
      .cfg_nonsec(cfg_nonsec), .cfg_page(cfg_page), .cfg_value(cfg_value),
      .viol_irq(viol_irq), .viol_clr(viol_clr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One request, checked in its own cycle (forwarding) and in the next (response).
   task automatic access(input string req, input logic [31:0] addr, input logic wr,
                         input logic ns, input logic exp_ok, input logic [31:0] exp_phys);
      @(negedge clk);
      req_valid = 1; req_addr = addr; req_write = wr; req_nonsec = ns;
      req_wdata = addr ^ 32'h0F0F_0F0F;
      #1;
      check({req, " forward"}, {31'd0, mem_valid}, {31'd0, exp_ok});
      if (exp_ok) begin
         check({req, " phys"}, mem_addr, exp_phys);
         check({req, " wdata"}, mem_wdata, addr ^ 32'h0F0F_0F0F);
      end
      @(negedge clk);
      check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
      check({req, " rsp_err"}, {31'd0, rsp_err}, {31'd0, !exp_ok});
      if (!exp_ok)       check({req, " R7 zero rdata"}, rsp_rdata, 32'd0);
      else if (!wr)      check({req, " R7 rdata"}, rsp_rdata, exp_phys ^ PAT);
      req_valid = 0; req_write = 0; req_nonsec = 0;
   endtask

   task automatic cfg(input logic [3:0] page, input logic val, input logic ns);
      @(negedge clk);
      cfg_wr = 1; cfg_page = page; cfg_value = val; cfg_nonsec = ns;
      @(negedge clk);
      cfg_wr = 0; cfg_nonsec = 0;
   endtask

   task automatic t_reset();
      #1;
      check("R10 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      check("R10 irq in reset", {31'd0, viol_irq}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      access("R10 page0 secure after reset", NSB + 32'h10, 0, 1, 0, 0);
      @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0;
   endtask

   task automatic t_secure_path();
      access("R1 secure read", SEC + 32'h10, 0, 0, 1, 32'h10);
      access("R1 secure write", SEC + 32'h3008, 1, 0, 1, 32'h3008);
      access("R1 top of memory", SEC + 32'hFFFC, 0, 0, 1, 32'hFFFC);
   endtask

   task automatic t_cfg_priv();
      cfg(4'd2, 1'b1, 1'b1);
      access("R9 ns cfg write ignored", NSB + 32'h2004, 0, 1, 0, 0);
      access("R4 ns window on secure page", NSB + 32'h1000, 0, 1, 0, 0);
      cfg(4'd2, 1'b1, 1'b0);
      access("R9 R2 ns page read", NSB + 32'h2004, 0, 1, 1, 32'h2004);
      access("R2 ns page write", NSB + 32'h2010, 1, 1, 1, 32'h2010);
   endtask

   task automatic t_mismatch();
      access("R4 secure window on ns page", SEC + 32'h2004, 0, 0, 0, 0);
      access("R3 ns requester on secure window", SEC + 32'h2004, 0, 1, 0, 0);
      access("R3 ns requester secure page", SEC + 32'h0000, 0, 1, 0, 0);
      access("R5 secure requester ns window", NSB + 32'h2004, 0, 0, 0, 0);
   endtask

   task automatic t_page_edges();
      access("R11 last byte of page 2", NSB + 32'h2FFF, 0, 1, 1, 32'h2FFF);
      access("R11 first byte of page 3", NSB + 32'h3000, 0, 1, 0, 0);
      access("R11 last byte of page 1", NSB + 32'h1FFF, 0, 1, 0, 0);
      cfg(4'd15, 1'b1, 1'b0);
      access("R11 R2 page 15 ns", NSB + 32'hF000, 0, 1, 1, 32'hF000);
      cfg(4'd2, 1'b0, 1'b0);
      access("R9 page 2 back to secure", SEC + 32'h2004, 0, 0, 1, 32'h2004);
   endtask

   task automatic t_outside();
      access("R6 unmapped address", 32'h3000_0000, 0, 0, 0, 0);
      access("R6 just past secure window", SEC + 32'h1_0000, 0, 0, 0, 0);
      access("R6 just below ns window", NSB - 32'h4, 1, 1, 0, 0);
   endtask

   task automatic t_irq();
      @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0; #1;
      check("R8 irq cleared", {31'd0, viol_irq}, 32'd0);
      access("R8 block raises irq", SEC + 32'h0, 1, 1, 0, 0);
      check("R8 irq set", {31'd0, viol_irq}, 32'd1);
      access("R8 good access keeps irq", SEC + 32'h0, 0, 0, 1, 32'h0);
      check("R8 irq still set", {31'd0, viol_irq}, 32'd1);
      @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0; #1;
      check("R8 irq cleared again", {31'd0, viol_irq}, 32'd0);
      @(negedge clk);
      req_valid = 1; req_addr = 32'h3000_0000; req_nonsec = 0; viol_clr = 1;
      @(negedge clk);
      req_valid = 0; viol_clr = 0;
      check("R8 block beats clear", {31'd0, viol_irq}, 32'd1);
   endtask

   initial begin
      t_reset();
      t_secure_path();
      t_cfg_priv();
      t_mismatch();
      t_page_edges();
      t_outside();
      t_irq();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule